// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation buffer. Each of its entries describes two neighbouring virtual pages, an even one and an odd one, that share one virtual tag but carry separate physical frame addresses and separate permission bits. A lookup takes a 32-bit virtual address, the 8-bit identifier of the running address space and an access kind (instruction fetch, data load or data store). It returns a physical address, a flag saying whether writes are allowed, and a 3-bit result code that names either a successful translation or the reason it failed.

Lookups flow through a valid/ready pair on each side. The search and the permission checks are combinational within one cycle, and the outcome is captured in a single output register. A request is accepted when `req_ready` is high. `req_ready` is high whenever the output register is empty or its contents are being taken in the same cycle. A response that is not taken holds its value unchanged until `rsp_ready` rises. Entries are loaded through a plain indexed write port. A write becomes visible to lookups accepted in the following cycle.

Each entry has a page-size mask. Bits set in this mask widen both pages of the pair: those bits are left out of the tag compare and become part of the page offset. The address bit just above the widened offset selects the even or odd half.

Top module: `ptlb_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every entry is marked hardware-invalid, so any lookup returns no-match.
- R2: An entry hits only if its invalidate bit is clear and either its global bit is set or its stored address-space ID equals `req_asid`.
- R3: Tag compare ignores the address bits set in the entry's page mask. It also always ignores bits 12..0, which are the 4 KB offset plus the half-select bit. The page mask must be a contiguous run of ones starting at bit 13, or all zero.
- R4: The half is chosen by the highest bit of the combined ignore mask, which is bit 12 for a zero page mask. When that bit is 0, the even fields are used. When it is 1, the odd fields are used.
- R5: After a hit, faults are checked in this order, and the first one that applies is reported. First, clear V gives code 3 (invalid). Second, a fetch (`req_acc`=0) with XI set gives code 6. Third, a load (`req_acc`=1) with RI set gives code 5. Fourth, a store (`req_acc`=2) with D clear gives code 4. If none applies, the code is 0 (match). Code 1 is reserved and never produced.
- R6: On a match, `rsp_pa` is the selected frame address ORed with the virtual address bits below the select bit.
- R7: On a match, `rsp_wr_ok` equals the selected D bit. On any other code, `rsp_wr_ok` and `rsp_pa` are 0.
- R8: If no entry hits, the code is 2 (no-match).
- R9: If several entries hit, the entry with the lowest index decides the result.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays stable and `req_ready` is 0. An accepted request yields `rsp_valid` on the next cycle.
- R11: When `wr_en` is 1, the entry at `wr_idx` is replaced. Each flag nibble is laid out as [3]=V, [2]=D, [1]=XI, [0]=RI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn2 | input | 32 | Virtual tag of the page pair (low bits ignored) |
| wr_pmask | input | 32 | Page-size mask, ones from bit 13 upward |
| wr_asid | input | 8 | Address-space ID of the entry |
| wr_global | input | 1 | Entry matches any address-space ID |
| wr_hinv | input | 1 | Entry is hardware-invalidated |
| wr_pfn_even | input | 32 | Frame address of the even half |
| wr_pfn_odd | input | 32 | Frame address of the odd half |
| wr_flags_even | input | 4 | V, D, XI, RI of the even half |
| wr_flags_odd | input | 4 | V, D, XI, RI of the odd half |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Current address-space ID |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_code | output | 3 | Result code |
| rsp_pa | output | 32 | Physical address |
| rsp_wr_ok | output | 1 | Write permitted |

## Verification
The bench sets up entries whose halves disagree. If the select bit were taken from the wrong position, a hit would come back with the wrong frame, or with a dirty fault instead of a match. Some halves carry several faults at once, so a design that checks them in the wrong order returns the wrong code. Other corner cases are overlapping entries (a design that lets the later one win reports the wrong address space), hardware-invalidated tags (a design that ignores that bit returns a hit), and wide page masks (a design that compares masked bits misses, or leaks them into the address). A stalled consumer checks that a response is neither dropped nor overwritten.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 32;
  localparam int ASID_W    = 8;
  localparam int MIN_SHIFT = 12;

  typedef enum logic [2:0] {
    RC_MATCH   = 3'd0,
    RC_BADADDR = 3'd1,
    RC_NOMATCH = 3'd2,
    RC_INVALID = 3'd3,
    RC_DIRTY   = 3'd4,
    RC_RINH    = 3'd5,
    RC_XINH    = 3'd6
  } rcode_e;

  typedef enum logic [1:0] {
    AC_FETCH = 2'd0,
    AC_LOAD  = 2'd1,
    AC_STORE = 2'd2
  } acc_e;

  typedef struct packed {
    logic v;
    logic d;
    logic xi;
    logic ri;
  } half_flags_t;

  typedef struct packed {
    logic [VA_W-1:0]   vpn2;
    logic [VA_W-1:0]   pmask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              hinv;
    logic [PA_W-1:0]   pfn0;
    logic [PA_W-1:0]   pfn1;
    half_flags_t       f0;
    half_flags_t       f1;
  } entry_t;
endpackage

// File: rtl/ptlb_slot.sv
module ptlb_slot
  import ptlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  entry_t            wdata,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic              odd,
  output logic [VA_W-1:0]   off_mask,
  output entry_t            q
);
  localparam logic [VA_W-1:0] LOW_IGN = VA_W'((64'd1 << (MIN_SHIFT + 1)) - 64'd1);

  logic [VA_W-1:0] cmp_mask;
  logic [VA_W-1:0] sel_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      q.hinv <= 1'b1;
    end else if (load) begin
      q <= wdata;
    end
  end

  always_comb begin
    cmp_mask = q.pmask | LOW_IGN;
    sel_bit  = cmp_mask & ~(cmp_mask >> 1);
    off_mask = cmp_mask >> 1;
    odd      = |(va & sel_bit);
    hit      = !q.hinv && (q.glob || (q.asid == asid)) &&
               ((va & ~cmp_mask) == (q.vpn2 & ~cmp_mask));
  end
endmodule

// File: rtl/ptlb_perm.sv
module ptlb_perm
  import ptlb_pkg::*;
(
  input  logic            any_hit,
  input  logic            odd,
  input  logic [VA_W-1:0] off_mask,
  input  entry_t          ent,
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      acc,
  output rcode_e          code,
  output logic [PA_W-1:0] pa,
  output logic            wr_ok
);
  half_flags_t     f;
  logic [PA_W-1:0] frame;

  always_comb begin
    f     = odd ? ent.f1 : ent.f0;
    frame = odd ? ent.pfn1 : ent.pfn0;
    if (!any_hit)                           code = RC_NOMATCH;
    else if (!f.v)                          code = RC_INVALID;
    else if (acc == AC_FETCH && f.xi)       code = RC_XINH;
    else if (acc == AC_LOAD && f.ri)        code = RC_RINH;
    else if (acc == AC_STORE && !f.d)       code = RC_DIRTY;
    else                                    code = RC_MATCH;
    if (code == RC_MATCH) begin
      pa    = frame | PA_W'(va & off_mask);
      wr_ok = f.d;
    end else begin
      pa    = '0;
      wr_ok = 1'b0;
    end
  end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn2,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PA_W-1:0]   wr_pfn_even,
  input  logic [PA_W-1:0]   wr_pfn_odd,
  input  logic [3:0]        wr_flags_even,
  input  logic [3:0]        wr_flags_odd,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_wr_ok
);
  entry_t          wdata;
  entry_t          ents   [ENTRIES];
  logic            hits   [ENTRIES];
  logic            odds   [ENTRIES];
  logic [VA_W-1:0] offs   [ENTRIES];

  entry_t          pick_ent;
  logic            pick_odd;
  logic [VA_W-1:0] pick_off;
  logic            any_hit;
  rcode_e          c_code;
  logic [PA_W-1:0] c_pa;
  logic            c_wr;

  always_comb begin
    wdata       = '0;
    wdata.vpn2  = wr_vpn2;
    wdata.pmask = wr_pmask;
    wdata.asid  = wr_asid;
    wdata.glob  = wr_global;
    wdata.hinv  = wr_hinv;
    wdata.pfn0  = wr_pfn_even;
    wdata.pfn1  = wr_pfn_odd;
    wdata.f0    = wr_flags_even;
    wdata.f1    = wr_flags_odd;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    ptlb_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en && (wr_idx == IDX_W'(i))),
      .wdata    (wdata),
      .va       (req_va),
      .asid     (req_asid),
      .hit      (hits[i]),
      .odd      (odds[i]),
      .off_mask (offs[i]),
      .q        (ents[i])
    );
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    any_hit  = 1'b0;
    pick_ent = ents[0];
    pick_odd = odds[0];
    pick_off = offs[0];
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit  = 1'b1;
        pick_ent = ents[i];
        pick_odd = odds[i];
        pick_off = offs[i];
      end
    end
  end

  ptlb_perm u_perm (
    .any_hit  (any_hit),
    .odd      (pick_odd),
    .off_mask (pick_off),
    .ent      (pick_ent),
    .va       (req_va),
    .acc      (req_acc),
    .code     (c_code),
    .pa       (c_pa),
    .wr_ok    (c_wr)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RC_NOMATCH;
      rsp_pa    <= '0;
      rsp_wr_ok <= 1'b0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_code  <= c_code;
      rsp_pa    <= c_pa;
      rsp_wr_ok <= c_wr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk
  import ptlb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2:0]      rsp_code,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_wr_ok
);
  // R7
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 3'd0) |-> (!rsp_wr_ok && rsp_pa == '0));

  // R5
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 3'd1 && rsp_code != 3'd7));

  // R10
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) &&
                                   $stable(rsp_pa) && $stable(rsp_wr_ok)));

  // R10
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind ptlb_top ptlb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_code  (rsp_code),
  .rsp_pa    (rsp_pa),
  .rsp_wr_ok (rsp_wr_ok)
);

// File: tb/ptlb_top_tb.sv
module ptlb_top_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_vpn2 = '0, wr_pmask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0, wr_hinv = 1'b0;
  logic [3:0]  wr_flags_even = '0, wr_flags_odd = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_pa;
  logic        rsp_wr_ok;

  int n_chk = 0;
  int n_bad = 0;

  // reference copy of the entries
  logic [31:0] m_vpn [N], m_pm [N], m_p0 [N], m_p1 [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N], m_hinv [N];
  logic [3:0]  m_f0 [N], m_f1 [N];

  always #2.5 clk = ~clk;

  ptlb_top u_dut (.*);

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] model(logic [31:0] va, logic [7:0] asid, logic [1:0] acc);
    logic [31:0] cm, pa;
    logic [3:0]  f;
    logic [2:0]  code;
    logic        odd;
    for (int i = 0; i < N; i++) begin
      cm = m_pm[i] | 32'h1FFF;
      if (!m_hinv[i] && (m_g[i] || m_asid[i] == asid) &&
          ((va & ~cm) == (m_vpn[i] & ~cm))) begin
        odd = |(va & cm & ~(cm >> 1));
        f   = odd ? m_f1[i] : m_f0[i];
        pa  = (odd ? m_p1[i] : m_p0[i]) | (va & (cm >> 1));
        if (!f[3])                  code = 3'd3;
        else if (acc == 0 && f[1])  code = 3'd6;
        else if (acc == 1 && f[0])  code = 3'd5;
        else if (acc == 2 && !f[2]) code = 3'd4;
        else                        code = 3'd0;
        if (code != 0) return {code, 32'h0, 1'b0};
        return {code, pa, f[2]};
      end
    end
    return {3'd2, 32'h0, 1'b0};
  endfunction

  task automatic wr(int idx, logic [31:0] vpn, logic [31:0] pm, logic [7:0] asid,
                    logic g, logic hinv, logic [31:0] p0, logic [31:0] p1,
                    logic [3:0] f0, logic [3:0] f1);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_vpn2 = vpn; wr_pmask = pm; wr_asid = asid;
    wr_global = g; wr_hinv = hinv; wr_pfn_even = p0; wr_pfn_odd = p1;
    wr_flags_even = f0; wr_flags_odd = f1;
    @(negedge clk);
    wr_en = 0;
    m_vpn[idx] = vpn; m_pm[idx] = pm; m_asid[idx] = asid; m_g[idx] = g;
    m_hinv[idx] = hinv; m_p0[idx] = p0; m_p1[idx] = p1; m_f0[idx] = f0; m_f1[idx] = f1;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, logic [1:0] acc, string req);
    @(negedge clk);
    req_valid = 1; req_va = va; req_asid = asid; req_acc = acc;
    @(negedge clk);
    req_valid = 0;
    check(req, {rsp_valid ? rsp_code : 3'd7, rsp_pa, rsp_wr_ok}, model(va, asid, acc));
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = 0; m_pm[i] = 0; m_p0[i] = 0; m_p1[i] = 0; m_asid[i] = 0;
      m_g[i] = 0; m_hinv[i] = 1; m_f0[i] = 0; m_f1[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid/req_ready", {34'h0, rsp_valid, req_ready}, 36'h1);
    rst_n = 1;
    look(32'h0040_0000, 8'd0, 2'd1, "R1 R8 lookup after reset");

    // simple pair, R6 R7 R4
    wr(0, 32'h0040_0000, 0, 8'd5, 0, 0, 32'h1000_0000, 32'h2000_0000, 4'b1100, 4'b1000);
    look(32'h0040_0123, 8'd5, 2'd1, "R6 R7 even half load");
    look(32'h0040_0123, 8'd5, 2'd2, "R7 even half store");
    look(32'h0040_1ABC, 8'd5, 2'd2, "R4 R5 odd half store dirty");
    look(32'h0040_1ABC, 8'd5, 2'd0, "R4 R7 odd half fetch");
    look(32'h0040_1ABC, 8'd6, 2'd0, "R2 R8 asid mismatch");
    // R11 R9 overlapping global entry
    wr(1, 32'h0040_0000, 0, 8'd9, 1, 0, 32'h3000_0000, 32'h4000_0000, 4'b1100, 4'b1100);
    look(32'h0040_0010, 8'd6, 2'd1, "R2 R11 global hit");
    look(32'h0040_1010, 8'd5, 2'd2, "R9 lowest index wins");
    // R2 hardware invalidate
    wr(2, 32'h0100_0000, 0, 8'd5, 1, 1, 32'h5000_0000, 32'h5000_0000, 4'b1100, 4'b1100);
    look(32'h0100_0000, 8'd5, 2'd1, "R2 hinv entry ignored");
    // R3 R4 wide page mask
    wr(3, 32'h0200_0000, 32'h001F_E000, 8'd5, 0, 0, 32'h6000_0000, 32'h7000_0000, 4'b1100, 4'b1100);
    look(32'h0213_4567, 8'd5, 2'd1, "R3 R4 R6 masked odd half");
    look(32'h020F_F000, 8'd5, 2'd2, "R3 R6 masked even half");
    look(32'h0220_0000, 8'd5, 2'd1, "R3 outside masked range");
    // R5 fault order
    wr(4, 32'h0300_0000, 0, 8'd5, 0, 0, 32'h0A00_0000, 32'h0B00_0000, 4'b0011, 4'b1011);
    look(32'h0300_0000, 8'd5, 2'd0, "R5 invalid before XI");
    look(32'h0300_0000, 8'd5, 2'd1, "R5 invalid before RI");
    look(32'h0300_1000, 8'd5, 2'd0, "R5 XI on fetch");
    look(32'h0300_1000, 8'd5, 2'd1, "R5 RI on load");
    look(32'h0300_1000, 8'd5, 2'd2, "R5 dirty on store");
    wr(5, 32'h0310_0000, 0, 8'd5, 0, 0, 32'h0C00_0000, 32'h0D00_0000, 4'b1001, 4'b1010);
    look(32'h0310_0040, 8'd5, 2'd0, "R5 R7 RI ignored for fetch");
    look(32'h0310_1040, 8'd5, 2'd1, "R5 XI ignored for load");

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_va = 32'h0040_0123; req_asid = 8'd5; req_acc = 2'd1;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      check("R10 held while stalled", {rsp_valid ? rsp_code : 3'd7, rsp_pa, req_ready},
            {3'd0, 32'h1000_0123, 1'b0});
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R10 drained", {35'h0, rsp_valid}, 36'h0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [31:0] bases [4] = '{32'h0040_0000, 32'h0200_0000, 32'h0400_0000, 32'h8000_0000};
        logic [31:0] pms [4] = '{32'h0, 32'h0000_6000, 32'h0001_E000, 32'h001F_E000};
        wr($urandom_range(0, N - 1), bases[$urandom_range(0, 3)], pms[$urandom_range(0, 3)],
           8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom_range(0, 7) == 0,
           $urandom & 32'hFFC0_0000, $urandom & 32'hFFC0_0000,
           4'($urandom), 4'($urandom));
      end else begin
        logic [31:0] b [4] = '{32'h0040_0000, 32'h0200_0000, 32'h0400_0000, 32'h8000_0000};
        look(b[$urandom_range(0, 3)] | ($urandom & 32'h003F_FFFF), 8'($urandom_range(0, 3)),
             2'($urandom_range(0, 2)), "R2 R3 R4 R5 R6 R7 R8 R9 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule